// File: doc/BRIEF.md
# CAN Bit Sampler with Programmable Sample Point

The block turns an oversampled single-wire CAN line into a stream of logical bits for a trigger or decode path. A free-running clock that is much faster than the bit rate samples the raw line through a two-flop synchroniser. A polarity input tells the block whether the recessive state is the high or the low line level. Either way, the block reports recessive as logic 1 and dominant as logic 0.

Each bit is divided into 32 time quanta. The quantum length comes from an integer bit-rate divisor that is computed outside the block; this covers both the fixed rates and any user rate. After reset, and after every re-enable, the block waits for the bus to be idle before it trusts any edge. Once the bus is idle, every recessive-to-dominant transition pulses an edge strobe and restarts bit timing at quantum zero, even in the middle of a bit. With no new transition, the timing wraps every 32 quanta, so runs of identical bits are still sampled. At a programmable quantum inside the bit, the block emits the polarity-corrected level together with a one-cycle valid strobe.

Top module: `can_bit_sampler`

## Requirements
- R1: With `rec_high_i`=1 a high line is recessive; with `rec_high_i`=0 a low line is recessive. In both cases `bit_o` is 1 for recessive and 0 for dominant.
- R2: After reset, or after `enable_i` rises, neither `edge_o` nor `bit_valid_o` pulses until the line has been recessive for 11 consecutive bit times (11·32·tq clocks). Any dominant level restarts this count.
- R3: Once idle has been seen, each recessive-to-dominant line change gives a one-cycle `edge_o` pulse on the third rising clock edge that samples the new level.
- R4: A recessive-to-dominant change restarts bit timing even in the middle of a bit. The next `bit_valid_o` comes 1+sp·tq cycles after `edge_o`, and any sample pending from the old timing is dropped.
- R5: The sample position sp equals `sp_code_i`, clamped to the range 6..29 quanta out of 32. For example, code 20 places the sample at 62.5% of the bit.
- R6: The quantum length tq is `div_i`>>5 clocks. Any divisor below 32 gives tq=1.
- R7: With no further transitions, `bit_valid_o` repeats every 32·tq clocks.
- R8: `bit_valid_o` is high for exactly one cycle per bit. `bit_o` holds the sampled, polarity-corrected level from that cycle until the next sample.
- R9: While `enable_i` is low, no strobe is issued from the next cycle on, and the idle wait of R2 is re-armed.
- R10: During and directly after reset, `bit_o`, `bit_valid_o` and `edge_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Run enable; low clears lock and timing |
| line_i | input | 1 | Raw bus line, asynchronous |
| rec_high_i | input | 1 | 1: recessive is the high level; 0: recessive is the low level |
| div_i | input | DIV_W | Clocks per bit |
| sp_code_i | input | 5 | Sample quantum code |
| bit_o | output | 1 | Last sampled logical bit |
| bit_valid_o | output | 1 | One-cycle strobe when `bit_o` is updated |
| edge_o | output | 1 | One-cycle strobe on a recessive-to-dominant change |

## Verification
The assertions assume that `div_i` and `sp_code_i` stay constant while `enable_i` is high. The stimulus respects this by changing the configuration only while the block is disabled. The line is assumed to settle between clock edges and the polarity to stay fixed while enabled. The bench changes the line only on falling clock edges and sets the polarity before enabling the block. With these assumptions, the quantum counter never exceeds its limit and two strobes of the same kind are never adjacent.

// File: rtl/can_bs_pkg.sv
package can_bs_pkg;
  localparam int unsigned QUANTA   = 32;
  localparam int unsigned Q_W      = $clog2(QUANTA);
  localparam int unsigned SP_MIN   = 6;
  localparam int unsigned SP_MAX   = 29;
  localparam int unsigned IDLE_BITS = 11;

  typedef logic [Q_W-1:0] quanta_t;

  function automatic quanta_t clamp_sp(input quanta_t code);
    if (code < quanta_t'(SP_MIN))      return quanta_t'(SP_MIN);
    else if (code > quanta_t'(SP_MAX)) return quanta_t'(SP_MAX);
    else                               return code;
  endfunction
endpackage

// File: rtl/can_bs_sync.sv
module can_bs_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  input  logic rst_val_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  // before the first samples arrive, report the neutral level
  logic primed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) primed_q <= 1'b0;
    else         primed_q <= 1'b1;
  end

  assign q_o = primed_q ? pipe_q[STAGES-1] : rst_val_i;
endmodule

// File: rtl/can_bs_front.sv
module can_bs_front #(
  parameter int unsigned CNT_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             line_s_i,
  input  logic             rec_high_i,
  input  logic [CNT_W-1:0] idle_lim_i,
  output logic             lvl_o,
  output logic             edge_o,
  output logic             locked_o
);
  logic             prev_q;
  logic [CNT_W-1:0] idle_q;
  logic             locked_q;
  logic             idle_hit;

  // logical level: 1 = recessive
  assign lvl_o    = rec_high_i ? line_s_i : ~line_s_i;
  assign idle_hit = (idle_q >= idle_lim_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q   <= 1'b1;
      idle_q   <= '0;
      locked_q <= 1'b0;
    end else begin
      prev_q <= lvl_o;
      if (!enable_i || !lvl_o)  idle_q <= '0;
      else if (!idle_hit)       idle_q <= idle_q + 1'b1;
      locked_q <= enable_i & (locked_q | idle_hit);
    end
  end

  assign edge_o   = enable_i & locked_q & prev_q & ~lvl_o;
  assign locked_o = locked_q;

  assert_edge_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |=> !edge_o);
  assert_lock_needs_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_q) |-> $past(enable_i) && $past(lvl_o));
endmodule

// File: rtl/can_bs_timer.sv
module can_bs_timer #(
  parameter int unsigned TQ_W = 11
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  enable_i,
  input  logic                  edge_i,
  input  logic [TQ_W-1:0]       tq_len_i,
  input  can_bs_pkg::quanta_t   sp_i,
  output logic                  sample_o
);
  import can_bs_pkg::*;

  logic            run_q;
  logic [TQ_W-1:0] clk_cnt_q;
  quanta_t         q_idx_q;
  logic            tq_end;

  assign tq_end = (clk_cnt_q == tq_len_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q     <= 1'b0;
      clk_cnt_q <= '0;
      q_idx_q   <= '0;
    end else if (!enable_i) begin
      run_q     <= 1'b0;
      clk_cnt_q <= '0;
      q_idx_q   <= '0;
    end else if (edge_i) begin
      run_q     <= 1'b1;
      clk_cnt_q <= '0;
      q_idx_q   <= '0;
    end else if (run_q) begin
      if (tq_end) begin
        clk_cnt_q <= '0;
        q_idx_q   <= q_idx_q + 1'b1; // wraps after 32 quanta
      end else begin
        clk_cnt_q <= clk_cnt_q + 1'b1;
      end
    end
  end

  assign sample_o = enable_i & run_q & ~edge_i & (clk_cnt_q == '0) & (q_idx_q == sp_i);

  assert_cnt_in_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && enable_i && $stable(tq_len_i) |-> clk_cnt_q < tq_len_i);
  assert_resync_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i && edge_i |=> q_idx_q == '0 && clk_cnt_q == '0 && run_q);
endmodule

// File: rtl/can_bit_sampler.sv
module can_bit_sampler #(
  parameter int unsigned DIV_W = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       enable_i,
  input  logic                       line_i,
  input  logic                       rec_high_i,
  input  logic [DIV_W-1:0]           div_i,
  input  logic [can_bs_pkg::Q_W-1:0] sp_code_i,
  output logic                       bit_o,
  output logic                       bit_valid_o,
  output logic                       edge_o
);
  import can_bs_pkg::*;

  localparam int unsigned TQ_W  = DIV_W - Q_W;
  localparam int unsigned CNT_W = DIV_W + 4;

  logic [TQ_W-1:0]  tq_len;
  logic [CNT_W-1:0] bit_clks;
  logic [CNT_W-1:0] idle_lim;
  quanta_t          sp_eff;
  logic             line_s, lvl, edge_det, locked, sample;

  assign tq_len   = (div_i[DIV_W-1:Q_W] == '0) ? TQ_W'(1) : div_i[DIV_W-1:Q_W];
  assign bit_clks = CNT_W'(tq_len) << Q_W;
  assign idle_lim = CNT_W'(bit_clks * CNT_W'(IDLE_BITS));
  assign sp_eff   = clamp_sp(sp_code_i);

  can_bs_sync #(.STAGES(2)) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .d_i      (line_i),
    .rst_val_i(rec_high_i),
    .q_o      (line_s)
  );

  can_bs_front #(.CNT_W(CNT_W)) u_front (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .enable_i  (enable_i),
    .line_s_i  (line_s),
    .rec_high_i(rec_high_i),
    .idle_lim_i(idle_lim),
    .lvl_o     (lvl),
    .edge_o    (edge_det),
    .locked_o  (locked)
  );

  can_bs_timer #(.TQ_W(TQ_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .enable_i(enable_i),
    .edge_i  (edge_det),
    .tq_len_i(tq_len),
    .sp_i    (sp_eff),
    .sample_o(sample)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_o       <= 1'b0;
      bit_valid_o <= 1'b0;
      edge_o      <= 1'b0;
    end else begin
      bit_valid_o <= sample;
      edge_o      <= edge_det;
      if (sample) bit_o <= lvl;
    end
  end

  assert_cfg_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i && $past(enable_i) |-> $stable(sp_code_i) && $stable(div_i));
  assert_valid_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_valid_o |=> !bit_valid_o);
  assert_quiet_disabled_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !bit_valid_o && !edge_o);
  assert_valid_locked_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_valid_o |-> $past(locked));
endmodule

// File: tb/can_bit_sampler_tb.sv
module can_bit_sampler_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        line = 1'b1;
  logic        rec_high = 1'b1;
  logic [15:0] div = 16'd64;
  logic [4:0]  sp = 5'd20;
  logic        bit_o, bit_valid, edge_s;

  always #2 clk = ~clk; // 250 MHz

  can_bit_sampler #(.DIV_W(16)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .line_i(line),
    .rec_high_i(rec_high), .div_i(div), .sp_code_i(sp),
    .bit_o(bit_o), .bit_valid_o(bit_valid), .edge_o(edge_s)
  );

  // {rec_high, div, sp_code, bits msb first}
  localparam int NV = 5;
  localparam logic [29:0] VEC [NV] = '{
    {1'b1, 16'd64,  5'd20, 8'b01101001},
    {1'b0, 16'd96,  5'd6,  8'b00111010},
    {1'b1, 16'd20,  5'd3,  8'b01010101},
    {1'b0, 16'd160, 5'd31, 8'b00011100},
    {1'b1, 16'd32,  5'd29, 8'b00000000}
  };

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int v_cyc [512];
  int v_bit [512];
  int e_cyc [512];
  int nv = 0, ne = 0, dbl = 0;
  logic prev_bv = 1'b0;
  always @(negedge clk) begin
    if (bit_valid) begin
      if (nv < 512) begin v_cyc[nv] = cyc; v_bit[nv] = int'(bit_o); end
      nv++;
      if (prev_bv) dbl++;
    end
    prev_bv = bit_valid;
    if (edge_s) begin
      if (ne < 512) e_cyc[ne] = cyc;
      ne++;
    end
  end

  int checks = 0, fails = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int tq_of(input int d);
    return (d < 32) ? 1 : (d >> 5);
  endfunction

  function automatic int sp_of(input int c);
    return (c < 6) ? 6 : ((c > 29) ? 29 : c);
  endfunction

  task automatic drive(input bit lvl, input int n, output int st);
    @(negedge clk);
    line = rec_high ? lvl : ~lvl;
    st = cyc + 1;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic setup(input bit rh, input int d, input int s);
    int st;
    @(negedge clk);
    en = 1'b0;
    rec_high = rh;
    div = 16'(d);
    sp = 5'(s);
    line = rh;
    repeat (4) @(negedge clk);
    en = 1'b1;
    drive(1'b1, 12 * 32 * tq_of(d), st);
  endtask

  initial begin
    int st, st2, bp, tq, spe, nv0, ne0, ebase;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(bit_o == 0 && bit_valid == 0 && edge_s == 0, "R10 reset outputs", int'({bit_o, bit_valid, edge_s}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(bit_o == 0 && bit_valid == 0 && edge_s == 0, "R10 after reset", int'({bit_o, bit_valid, edge_s}), 0);

    // vector table
    for (int v = 0; v < NV; v++) begin
      logic [7:0] bits;
      int starts [8];
      int last_e;
      bits = VEC[v][7:0];
      setup(VEC[v][29], int'(VEC[v][28:13]), int'(VEC[v][12:8]));
      tq  = tq_of(int'(VEC[v][28:13]));
      spe = sp_of(int'(VEC[v][12:8]));
      bp  = 32 * tq;
      nv0 = nv; ne0 = ne;
      for (int i = 0; i < 8; i++) drive(bits[7-i], bp, starts[i]);
      drive(1'b1, 2 * bp, st);
      chk(nv - nv0 >= 8, "R7 sample count", nv - nv0, 8);
      last_e = starts[0];
      ebase = ne0;
      for (int i = 0; i < 8; i++) begin
        int exp_c;
        bit prev;
        prev = (i == 0) ? 1'b1 : bits[8-i];
        if (prev && !bits[7-i]) begin
          last_e = starts[i];
          chk(e_cyc[ebase] == starts[i] + 2, "R3 edge timing", e_cyc[ebase], starts[i] + 2);
          ebase++;
        end
        exp_c = starts[i] + 3 + spe * tq;
        chk(v_cyc[nv0+i] == exp_c, "R5/R6/R7 sample cycle", v_cyc[nv0+i], exp_c);
        chk(v_bit[nv0+i] == int'(bits[7-i]), "R1/R8 bit value", v_bit[nv0+i], int'(bits[7-i]));
      end
      chk(ne == ebase, "R3 edge count", ne - ne0, ebase - ne0);
    end
    chk(dbl == 0, "R8 single-cycle strobe", dbl, 0);

    // R2: edge before idle is ignored, and a dominant level restarts the idle count
    @(negedge clk); en = 1'b0; rec_high = 1'b1; div = 16'd64; sp = 5'd20; line = 1'b1;
    repeat (4) @(negedge clk);
    en = 1'b1;
    nv0 = nv; ne0 = ne;
    drive(1'b1, 5 * 64, st);
    drive(1'b0, 64, st);
    drive(1'b1, 8 * 64, st);
    drive(1'b0, 64, st);
    drive(1'b1, 2 * 64, st);
    chk(nv == nv0 && ne == ne0, "R2 no strobe before idle", nv - nv0 + ne - ne0, 0);
    drive(1'b1, 12 * 64, st);
    drive(1'b0, 64, st);
    drive(1'b1, 64, st2);
    chk(ne == ne0 + 1 && e_cyc[ne0] == st + 2, "R2 edge after idle", e_cyc[ne0], st + 2);

    // R4: mid-bit resync, tq=2 sp=20
    setup(1'b1, 64, 20);
    nv0 = nv;
    drive(1'b0, 64, st);
    drive(1'b1, 10, st2);
    drive(1'b0, 64, st2);
    drive(1'b1, 3 * 64, bp);
    chk(v_cyc[nv0] == st + 43, "R4 first sample", v_cyc[nv0], st + 43);
    chk(v_cyc[nv0+1] == st2 + 43, "R4 resync sample", v_cyc[nv0+1], st2 + 43);
    chk(v_bit[nv0+1] == 0, "R4 resync value", v_bit[nv0+1], 0);

    // R9: disable suppresses strobes and re-arms the idle wait
    nv0 = nv; ne0 = ne;
    @(negedge clk); en = 1'b0;
    drive(1'b0, 64, st);
    drive(1'b1, 2 * 64, st);
    chk(nv == nv0 && ne == ne0, "R9 quiet while disabled", nv - nv0 + ne - ne0, 0);
    @(negedge clk); en = 1'b1;
    drive(1'b1, 2 * 64, st);
    drive(1'b0, 64, st);
    drive(1'b1, 2 * 64, st);
    chk(nv == nv0 && ne == ne0, "R9 idle wait re-armed", nv - nv0 + ne - ne0, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails + 1);
      $finish;
    end
  end
endmodule